// File: doc/BRIEF.md
# Paged ROM Table Lookup Unit

This unit serves a 4-bit core that reads constant tables out of program ROM. A lookup command carries a 7-bit page number. The unit joins that page with a 3-bit pointer register D and the 4-bit accumulator A to form a 14-bit ROM word address. It then issues a single read request to an external synchronous ROM port. The returned 10-bit word is written into the B:A register pair.

A mode flag decides whether a lookup also updates D. When the flag is set, the two most significant bits of the returned word are written into the low bits of D, and the top bit of D is forced to zero. When the flag is clear, D is left as it was.

Two commands manage the flag: one sets it and one clears it. The concatenation D:A is always driven out as a 7-bit in-page pointer for indirect jumps. D powers up with no defined value, so it must be written through its load port before it is used. The accumulator has a matching load port.

Top module: `tbl_lookup_unit`

## Requirements
- R1: While `rom_req` is high, `rom_addr` equals {page, D, A}. The page occupies bits [13:7], D bits [6:4] and A bits [3:0], using the page from the accepted command and the D and A values present in that command's cycle.
- R2: An accepted lookup drives `rom_req` high for exactly one cycle, namely the cycle that follows the acceptance edge.
- R3: The ROM word is sampled in the cycle after `rom_req`. At the next edge, word bits [7:4] are written into B and word bits [3:0] into A.
- R4: When the mode flag is 1 at the writeback edge, D becomes {1'b0, word[9:8]}.
- R5: When the mode flag is 0 at the writeback edge, the lookup leaves D unchanged.
- R6: `flag_set` makes the flag 1 and `flag_clr` makes it 0, both at the next edge. If both are high in the same cycle, set wins.
- R7: During reset and right after it, `mode_flag`, `busy`, `rom_req`, A and B are all 0.
- R8: `busy` is high from the cycle after acceptance up to the writeback edge, which is two cycles in all. A lookup command that arrives while `busy` is high is ignored.
- R9: `d_load` and `a_load` write their registers at the next edge. If a writeback at that same edge also writes the register, the writeback wins.
- R10: `jump_ptr` always equals {D, A}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released inside |
| lk_start | input | 1 | Lookup command |
| lk_page | input | 7 | Page number from the instruction |
| flag_set | input | 1 | Set the mode flag |
| flag_clr | input | 1 | Clear the mode flag |
| d_load | input | 1 | Write D |
| d_load_val | input | 3 | Value for D |
| a_load | input | 1 | Write A |
| a_load_val | input | 4 | Value for A |
| rom_req | output | 1 | ROM read request, one cycle |
| rom_addr | output | 14 | ROM word address |
| rom_rdata | input | 10 | ROM word, valid the cycle after the request |
| acc_a | output | 4 | Accumulator A |
| reg_b | output | 4 | Register B |
| ptr_d | output | 3 | Pointer register D |
| jump_ptr | output | 7 | In-page jump pointer {D, A} |
| busy | output | 1 | Lookup in flight |
| mode_flag | output | 1 | Mode flag controlling D writeback |

## Verification
Take the edge that accepts a lookup as edge 0. The request and its address appear in the cycle after edge 0. The ROM model returns the word one cycle after that. B, A and, when the flag is set, D take their new values after edge 2. Flag commands and direct loads show up after a single edge. A behavioural model in the bench applies these latencies edge by edge, using its own stage counter and a copy of the ROM contents. Every output is compared on the falling edge between rising edges, so each result is checked in the exact cycle it is due.

// File: rtl/tbl_lookup_pkg.sv
package tbl_lookup_pkg;
  localparam int unsigned PAGE_W = 7;
  localparam int unsigned PTR_W  = 3;
  localparam int unsigned ACC_W  = 4;
  localparam int unsigned WORD_W = 10;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_REQ  = 2'd1,
    LK_WAIT = 2'd2
  } lk_state_e;
endpackage

// File: rtl/tbl_lookup_seq.sv
module tbl_lookup_seq
  import tbl_lookup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic req,
  output logic commit
);
  lk_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LK_IDLE: if (start) st_d = LK_REQ;
      LK_REQ:  st_d = LK_WAIT;
      LK_WAIT: st_d = LK_IDLE;
      default: st_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_IDLE;
    else        st_q <= st_d;
  end

  assign accept = (st_q == LK_IDLE) && start;
  assign busy   = (st_q != LK_IDLE);
  assign req    = (st_q == LK_REQ);
  assign commit = (st_q == LK_WAIT);
endmodule

// File: rtl/tbl_lookup_addr.sv
module tbl_lookup_addr #(
  parameter int unsigned PAGE_W = 7,
  parameter int unsigned PTR_W  = 3,
  parameter int unsigned ACC_W  = 4,
  localparam int unsigned ADDR_W = PAGE_W + PTR_W + ACC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [PAGE_W-1:0] page,
  input  logic [PTR_W-1:0]  ptr_hi,
  input  logic [ACC_W-1:0]  ptr_lo,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = capture;
    addr_d  = {page, ptr_hi, ptr_lo};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/tbl_lookup_regs.sv
module tbl_lookup_regs #(
  parameter int unsigned PTR_W  = 3,
  parameter int unsigned ACC_W  = 4,
  parameter int unsigned WORD_W = 10,
  localparam int unsigned HI_W  = WORD_W - 2 * ACC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  input  logic              flag_set,
  input  logic              flag_clr,
  input  logic              d_we,
  input  logic [PTR_W-1:0]  d_wdata,
  input  logic              a_we,
  input  logic [ACC_W-1:0]  a_wdata,
  output logic [ACC_W-1:0]  a_out,
  output logic [ACC_W-1:0]  b_out,
  output logic [PTR_W-1:0]  d_out,
  output logic              flag_out
);
  logic [ACC_W-1:0] a_q, a_d, b_q, b_d;
  logic [PTR_W-1:0] d_q, d_d, d_from_word;
  logic             flag_q, flag_d;
  logic             a_en, b_en, d_en, d_cap, flag_en;

  generate
    if (HI_W < PTR_W) begin : g_pad
      assign d_from_word = {{(PTR_W - HI_W){1'b0}}, word[WORD_W-1 -: HI_W]};
    end else begin : g_trunc
      assign d_from_word = word[2*ACC_W +: PTR_W];
    end
  endgenerate

  always_comb begin
    a_en    = commit | a_we;
    a_d     = commit ? word[ACC_W-1:0] : a_wdata;
    b_en    = commit;
    b_d     = word[2*ACC_W-1:ACC_W];
    d_cap   = commit & flag_q;
    d_en    = d_cap | d_we;
    d_d     = d_cap ? d_from_word : d_wdata;
    flag_en = flag_set | flag_clr;
    flag_d  = flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      flag_q <= 1'b0;
    end else begin
      if (a_en)    a_q    <= a_d;
      if (b_en)    b_q    <= b_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk) begin
    if (d_en) d_q <= d_d;
  end

  assign a_out    = a_q;
  assign b_out    = b_q;
  assign d_out    = d_q;
  assign flag_out = flag_q;
endmodule

// File: rtl/tbl_lookup_unit.sv
module tbl_lookup_unit
  import tbl_lookup_pkg::*;
#(
  parameter int unsigned P_PAGE_W = tbl_lookup_pkg::PAGE_W,
  parameter int unsigned P_PTR_W  = tbl_lookup_pkg::PTR_W,
  parameter int unsigned P_ACC_W  = tbl_lookup_pkg::ACC_W,
  parameter int unsigned P_WORD_W = tbl_lookup_pkg::WORD_W,
  localparam int unsigned ADDR_W  = P_PAGE_W + P_PTR_W + P_ACC_W,
  localparam int unsigned JMP_W   = P_PTR_W + P_ACC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_start,
  input  logic [P_PAGE_W-1:0] lk_page,
  input  logic                flag_set,
  input  logic                flag_clr,
  input  logic                d_load,
  input  logic [P_PTR_W-1:0]  d_load_val,
  input  logic                a_load,
  input  logic [P_ACC_W-1:0]  a_load_val,
  output logic                rom_req,
  output logic [ADDR_W-1:0]   rom_addr,
  input  logic [P_WORD_W-1:0] rom_rdata,
  output logic [P_ACC_W-1:0]  acc_a,
  output logic [P_ACC_W-1:0]  reg_b,
  output logic [P_PTR_W-1:0]  ptr_d,
  output logic [JMP_W-1:0]    jump_ptr,
  output logic                busy,
  output logic                mode_flag
);
  logic rs_meta_q, rst_core_n;
  logic accept, commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q  <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rs_meta_q  <= 1'b1;
      rst_core_n <= rs_meta_q;
    end
  end

  tbl_lookup_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .start  (lk_start),
    .accept (accept),
    .busy   (busy),
    .req    (rom_req),
    .commit (commit)
  );

  tbl_lookup_addr #(
    .PAGE_W (P_PAGE_W),
    .PTR_W  (P_PTR_W),
    .ACC_W  (P_ACC_W)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .capture (accept),
    .page    (lk_page),
    .ptr_hi  (ptr_d),
    .ptr_lo  (acc_a),
    .addr    (rom_addr)
  );

  tbl_lookup_regs #(
    .PTR_W  (P_PTR_W),
    .ACC_W  (P_ACC_W),
    .WORD_W (P_WORD_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .commit   (commit),
    .word     (rom_rdata),
    .flag_set (flag_set),
    .flag_clr (flag_clr),
    .d_we     (d_load),
    .d_wdata  (d_load_val),
    .a_we     (a_load),
    .a_wdata  (a_load_val),
    .a_out    (acc_a),
    .b_out    (reg_b),
    .d_out    (ptr_d),
    .flag_out (mode_flag)
  );

  // R10: in-page pointer for indirect jumps
  assign jump_ptr = {ptr_d, acc_a};
endmodule

// File: rtl/tbl_lookup_chk.sv
module tbl_lookup_chk #(
  parameter int unsigned PTR_W  = 3,
  parameter int unsigned ACC_W  = 4,
  parameter int unsigned WORD_W = 10,
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flag_set,
  input logic              flag_clr,
  input logic              d_wr_en,
  input logic              rom_req,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [WORD_W-1:0] rom_rdata,
  input logic              busy,
  input logic              mode_flag,
  input logic [PTR_W-1:0]  reg_d,
  input logic [ACC_W-1:0]  acc_a,
  input logic [ACC_W-1:0]  reg_b
);
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req |=> !rom_req);

  p_req_leads_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> rom_req);

  p_addr_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rom_req) |-> $stable(rom_addr));

  p_a_writeback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rom_req) |=> acc_a == $past(rom_rdata[ACC_W-1:0]));

  p_b_writeback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rom_req) |=> reg_b == $past(rom_rdata[2*ACC_W-1:ACC_W]));

  p_d_top_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rom_req && mode_flag) |=> !reg_d[PTR_W-1]);

  p_d_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rom_req && !mode_flag && !d_wr_en) |=> $stable(reg_d));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> mode_flag);

  p_flag_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !flag_set) |=> !mode_flag);

  p_busy_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req |=> busy ##1 !busy);

  p_no_req_in_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rom_req);
endmodule

bind tbl_lookup_unit tbl_lookup_chk #(
  .PTR_W  (P_PTR_W),
  .ACC_W  (P_ACC_W),
  .WORD_W (P_WORD_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .flag_set  (flag_set),
  .flag_clr  (flag_clr),
  .d_wr_en   (d_load),
  .rom_req   (rom_req),
  .rom_addr  (rom_addr),
  .rom_rdata (rom_rdata),
  .busy      (busy),
  .mode_flag (mode_flag),
  .reg_d     (ptr_d),
  .acc_a     (acc_a),
  .reg_b     (reg_b)
);

// File: tb/tbl_lookup_unit_bench.sv
module tbl_lookup_unit_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_start;
  logic [6:0]  lk_page;
  logic        flag_set, flag_clr;
  logic        d_load;
  logic [2:0]  d_load_val;
  logic        a_load;
  logic [3:0]  a_load_val;
  logic        rom_req;
  logic [13:0] rom_addr;
  logic [9:0]  rom_rdata = '0;
  logic [3:0]  acc_a, reg_b;
  logic [2:0]  ptr_d;
  logic [6:0]  jump_ptr;
  logic        busy, mode_flag;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_P/2) clk = ~clk;

  tbl_lookup_unit u_tbl_lookup_unit (
    .clk(clk), .rst_n(rst_n), .lk_start(lk_start), .lk_page(lk_page),
    .flag_set(flag_set), .flag_clr(flag_clr),
    .d_load(d_load), .d_load_val(d_load_val),
    .a_load(a_load), .a_load_val(a_load_val),
    .rom_req(rom_req), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .acc_a(acc_a), .reg_b(reg_b), .ptr_d(ptr_d), .jump_ptr(jump_ptr),
    .busy(busy), .mode_flag(mode_flag)
  );

  function automatic logic [9:0] rom_word(input logic [13:0] adr);
    int v;
    v = (int'(adr) * 173) ^ (int'(adr) >> 4) ^ 347;
    return v[9:0];
  endfunction

  // synchronous ROM model: word appears the cycle after the request
  always @(posedge clk) if (rom_req) rom_rdata <= rom_word(rom_addr);

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // behavioural reference model
  logic [3:0]  m_a = '0, m_b = '0;
  logic [2:0]  m_d = '0;
  logic        m_flag = 1'b0;
  logic [13:0] m_addr = '0;
  int          m_stage = 0;
  int          rs = 0;
  bit          d_known = 1'b0;

  always @(posedge clk) begin
    bit          in_rst, wb;
    logic [9:0]  w;
    logic [3:0]  na;
    logic [2:0]  nd;
    in_rst = !rst_n || (rs < 2);
    wb     = !in_rst && (m_stage == 2);
    w      = rom_word(m_addr);
    nd     = m_d;
    if (wb && m_flag) begin
      nd = {1'b0, w[9:8]};
      d_known = 1'b1;
    end else if (d_load) begin
      nd = d_load_val;
      d_known = 1'b1;
    end
    if (in_rst) begin
      m_a = '0; m_b = '0; m_flag = 1'b0; m_stage = 0;
    end else begin
      na = wb ? w[3:0] : (a_load ? a_load_val : m_a);
      if (wb) m_b = w[7:4];
      if (m_stage == 0 && lk_start) begin
        m_addr  = {lk_page, m_d, m_a};
        m_stage = 1;
      end else if (m_stage == 1) m_stage = 2;
      else if (m_stage == 2) m_stage = 0;
      if (flag_set) m_flag = 1'b1;
      else if (flag_clr) m_flag = 1'b0;
      m_a = na;
    end
    m_d = nd;
    if (!rst_n) rs = 0;
    else if (rs < 2) rs++;
  end

  always @(negedge clk) begin
    if (rst_n && rs >= 2) begin
      chk("R8", "busy", busy, (m_stage != 0));
      chk("R2", "rom_req", rom_req, (m_stage == 1));
      if (m_stage == 1) chk("R1", "rom_addr", rom_addr, m_addr);
      chk("R3", "acc_a", acc_a, m_a);
      chk("R3", "reg_b", reg_b, m_b);
      chk("R6", "mode_flag", mode_flag, m_flag);
      if (d_known) begin
        chk("R4", "ptr_d", ptr_d, m_d);
        chk("R10", "jump_ptr", jump_ptr, {m_d, m_a});
      end
    end
  end

  task automatic drive(input bit st, input logic [6:0] pg, input bit fs, input bit fc,
                       input bit dl, input logic [2:0] dv, input bit al, input logic [3:0] av);
    @(negedge clk);
    lk_start = st; lk_page = pg; flag_set = fs; flag_clr = fc;
    d_load = dl; d_load_val = dv; a_load = al; a_load_val = av;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, '0, 0, 0, 0, '0, 0, '0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    rst_n = 1'b0;
    lk_start = 0; lk_page = '0; flag_set = 0; flag_clr = 0;
    d_load = 0; d_load_val = '0; a_load = 0; a_load_val = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    @(negedge clk);
    // R7: reset state
    chk("R7", "mode_flag", mode_flag, 0);
    chk("R7", "busy", busy, 0);
    chk("R7", "rom_req", rom_req, 0);
    chk("R7", "acc_a", acc_a, 0);
    chk("R7", "reg_b", reg_b, 0);

    // R5: flag clear, D survives the lookup
    drive(0, '0, 0, 0, 1, 3'd5, 1, 4'h9);
    drive(1, 7'h23, 0, 0, 0, '0, 0, '0);
    idle(4);
    @(negedge clk);
    chk("R5", "ptr_d after lookup", ptr_d, 5);
    chk("R3", "reg_b after lookup", reg_b, rom_word({7'h23, 3'd5, 4'h9}) >> 4 & 4'hF);

    // R4: flag set, D takes word top bits
    drive(0, '0, 1, 0, 1, 3'd3, 1, 4'hC);
    drive(1, 7'h7F, 0, 0, 0, '0, 0, '0);
    idle(4);
    @(negedge clk);
    chk("R4", "ptr_d from word", ptr_d, {1'b0, rom_word({7'h7F, 3'd3, 4'hC}) >> 8 & 2'h3});

    // R8: commands while busy are ignored
    drive(1, 7'h10, 0, 0, 0, '0, 0, '0);
    drive(1, 7'h55, 0, 0, 0, '0, 0, '0);
    drive(1, 7'h56, 0, 0, 0, '0, 0, '0);
    idle(4);

    // R6: set and clear together, set wins
    drive(0, '0, 1, 1, 0, '0, 0, '0);
    drive(0, '0, 0, 1, 0, '0, 0, '0);
    drive(0, '0, 1, 1, 0, '0, 0, '0);
    idle(1);
    @(negedge clk);
    chk("R6", "set beats clear", mode_flag, 1);

    // R9: direct loads colliding with writeback (flag 1)
    drive(1, 7'h41, 0, 0, 0, '0, 0, '0);
    idle(1);
    drive(0, '0, 0, 0, 1, 3'd7, 1, 4'h0);
    idle(1);
    @(negedge clk);
    chk("R9", "ptr_d writeback wins", ptr_d, m_d);
    chk("R9", "acc_a writeback wins", acc_a, m_a);

    // R9: flag 0, D load at writeback edge is taken
    drive(0, '0, 0, 1, 1, 3'd6, 0, '0);
    drive(1, 7'h02, 0, 0, 0, '0, 0, '0);
    idle(1);
    drive(0, '0, 0, 0, 1, 3'd1, 0, '0);
    idle(1);
    @(negedge clk);
    chk("R9", "ptr_d load at writeback", ptr_d, 1);

    // mixed traffic
    seed = 32'h1234_5678;
    for (int i = 0; i < 2000; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      drive(seed[20:19] != 2'b00, seed[30:24], seed[17:15] == 3'b000, seed[14:12] == 3'b000,
            seed[11:10] == 2'b00, seed[9:7], seed[6:5] == 2'b00, seed[4:1]);
    end
    idle(5);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule